// File: doc/BRIEF.md
# Threshold-Gated Transmit Byte Queue with Frame Abort

This block sits between a DMA engine that fills it one byte at a time and a media-side byte stream that sends one byte per clock once a frame is under way. Every stored byte carries an end-of-frame flag. A new frame does not start until the number of buffered bytes is greater than a start threshold that software can write. A larger threshold makes it less likely that the queue runs dry partway through a frame. A frame whose end flag is already stored, or a full queue, also releases the start. Without that rule a short frame, or a threshold as large as the storage, would never be sent.

Once a frame has started, two events can cut it short. The first is an underflow: the queue is empty before the end flag has gone out. The second is an external transmit-error input. In either case `tx_en` drops on the following cycle, the frame's remaining bytes are never put on the media, and a one-cycle event pulse goes to a status sequencer together with the index of the cut frame. If the DMA has not yet written the frame's end flag, `fill_abort` pulses to tell the DMA to stop, and the whole queue is emptied at once. If the end flag is already stored, the leftover bytes up to and including that flag are discarded one per clock, and any frames stored behind them are kept.

The controller has three states. IDLE waits for a start. SEND puts one byte per clock on the media. DRAIN discards the leftover bytes of a cut frame.

Its transitions are:
- IDLE→SEND (start): a start is allowed and the first byte is not the end of the frame. For a one-byte frame the controller stays in IDLE.
- SEND→IDLE (done): the end byte is sent.
- SEND→IDLE (cut and flush): a cut happens and the frame's end flag is not stored.
- SEND→DRAIN (cut and drain): a cut happens and the frame's end flag is stored.
- DRAIN→IDLE (drained): the end byte is discarded.

Top module: `tx_gate_fifo`

## Requirements
- R1: After reset, `fill_ready` is 1. `tx_en`, `tx_eop`, `underflow_event`, `abort_event` and `fill_abort` are 0, and `event_frame` is 0.
- R2: A write with `thr_we` high loads `thr_val` into the start threshold. A frame whose end flag is not stored starts only when the queue holds more bytes than the threshold. A threshold of 0 starts as soon as one byte is held.
- R3: A frame also starts, whatever the threshold, when its end flag (`fill_last`=1 on a byte) is stored or when the queue is full.
- R4: A started frame is sent one byte per cycle in write order with `tx_en`=1. `tx_eop`=1 marks only its end byte.
- R5: If the queue is empty in SEND, `underflow_event` pulses for one cycle. `tx_en` is 0 in that same cycle, and no further byte of that frame is sent.
- R6: If `tx_err` is high in SEND, `abort_event` pulses for one cycle and `tx_en` is 0 in that same cycle. No further byte of that frame is sent.
- R7: If a cut happens while the frame's end flag is not stored, `fill_abort` pulses for one cycle and the queue is emptied. `fill_ready` is 0 in the cycle in which the cut is taken.
- R8: If a cut happens while the frame's end flag is stored, `fill_abort` stays 0. The leftover bytes of the frame, up to and including the end flag, never reach the media. The next stored frame is sent intact.
- R9: The frame index starts at 0 and goes up by one for every frame that ends, whether sent whole or cut. `event_frame` gives the index of the cut frame when an event pulses.
- R10: `fill_ready` is 0 while the queue holds DEPTH bytes, and no stored byte is overwritten.
- R11: `tx_err` has no effect outside SEND: no `abort_event` pulses, and `fill_ready` stays 1.
- R12: An underflow and a `tx_err` in the same SEND cycle raise both event pulses in the same cycle and a single `fill_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Start-threshold write strobe |
| thr_val | input | CW | New start threshold in bytes |
| fill_valid | input | 1 | DMA offers a byte |
| fill_data | input | 8 | Byte from DMA |
| fill_last | input | 1 | Byte is the last of its frame |
| fill_ready | output | 1 | Byte is accepted this cycle |
| fill_abort | output | 1 | Pulse: stop filling the cut frame |
| tx_err | input | 1 | External transmit error |
| tx_en | output | 1 | Media byte valid |
| tx_data | output | 8 | Media byte |
| tx_eop | output | 1 | Media byte ends the frame |
| underflow_event | output | 1 | Pulse: frame cut by underflow |
| abort_event | output | 1 | Pulse: frame cut by error |
| event_frame | output | IDX_W | Index of the cut frame |

## Verification
Underflow detection and the external-error abort can act in the same SEND cycle. The bench provokes this by sending a single byte with no end flag under a zero threshold, then raising `tx_err` exactly in the cycle in which the queue turns empty. It is judged correct when both pulses are seen in one cycle, `fill_abort` counts up once, and both events report the same frame index. A second overlap is also provoked: an error abort is drained away while the next frame is still being written. Here the bench checks that the draining cycles and the new writes keep the byte order and the frame boundaries intact.

// File: rtl/txg_pkg.sv
package txg_pkg;

    parameter int unsigned TXG_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_DRAIN = 2'd2
    } txg_state_e;

    typedef struct packed {
        logic              eof;
        logic [TXG_DW-1:0] byte_v;
    } txg_slot_t;

endpackage

// File: rtl/txg_store.sv
module txg_store
    import txg_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  txg_slot_t      wr_slot,
    input  logic           rd_en,
    input  logic           flush,
    output txg_slot_t      head,
    output logic [CW-1:0]  level,
    output logic           eof_held,
    output logic           full,
    output logic           empty
);

    txg_slot_t         mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q, eofs_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            eofs_q <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (flush) begin
                rd_ptr <= wr_ptr;
                cnt_q  <= '0;
                eofs_q <= '0;
            end else begin
                if (rd_en) rd_ptr <= bump(rd_ptr);
                cnt_q  <= cnt_q + CW'(wr_en) - CW'(rd_en);
                eofs_q <= eofs_q + CW'(wr_en && wr_slot.eof) - CW'(rd_en && head.eof);
            end
        end
    end

    assign head     = mem[rd_ptr];
    assign level    = cnt_q;
    assign eof_held = (eofs_q != '0);
    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);

    // R10: a full queue never takes a write
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    // R10: the level never passes the storage depth
    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    // R4: no byte is taken from an empty queue
    p_no_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
    // R7: a flush and a write never share a cycle
    p_flush_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !wr_en);
    // R8: end flags held never exceed bytes held
    p_eof_le_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eofs_q <= cnt_q);

endmodule

// File: rtl/txg_start_cmp.sv
module txg_start_cmp #(
    parameter int unsigned DEPTH    = 16,
    localparam int unsigned CW      = $clog2(DEPTH + 1),
    parameter int unsigned THR_INIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_we,
    input  logic [CW-1:0] thr_val,
    input  logic [CW-1:0] level,
    input  logic          eof_held,
    input  logic          full,
    output logic          start_ok
);

    logic [CW-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= CW'(THR_INIT);
        else if (thr_we) thr_q <= thr_val;
    end

    assign start_ok = (level > thr_q) || eof_held || full;

    // R2: a threshold write lands in the register
    p_thr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (thr_q == $past(thr_val)));

endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
    import txg_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              empty,
    input  logic              eof_held,
    input  txg_slot_t         head,
    input  logic              tx_err,
    output logic              rd_en,
    output logic              flush,
    output logic              tx_en,
    output logic [TXG_DW-1:0] tx_data,
    output logic              tx_eop,
    output logic              uf_evt,
    output logic              ab_evt,
    output logic              fill_abort,
    output logic [IDX_W-1:0]  evt_frame
);

    txg_state_e       st, nxt;
    logic             to_media, cut, fin;
    logic [IDX_W-1:0] frame_q;

    always_comb begin
        nxt      = st;
        rd_en    = 1'b0;
        flush    = 1'b0;
        to_media = 1'b0;
        cut      = 1'b0;
        fin      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_ok) begin
                    rd_en    = 1'b1;
                    to_media = 1'b1;
                    if (head.eof) fin = 1'b1;
                    else          nxt = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_err || empty) begin
                    cut   = 1'b1;
                    flush = !eof_held;
                    nxt   = eof_held ? ST_DRAIN : ST_IDLE;
                end else begin
                    rd_en    = 1'b1;
                    to_media = 1'b1;
                    if (head.eof) begin
                        fin = 1'b1;
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_DRAIN: begin
                if (!empty) begin
                    rd_en = 1'b1;
                    if (head.eof) nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en      <= 1'b0;
            tx_data    <= '0;
            tx_eop     <= 1'b0;
            uf_evt     <= 1'b0;
            ab_evt     <= 1'b0;
            fill_abort <= 1'b0;
            evt_frame  <= '0;
            frame_q    <= '0;
        end else begin
            tx_en      <= to_media;
            if (to_media) tx_data <= head.byte_v;
            tx_eop     <= to_media && head.eof;
            uf_evt     <= (st == ST_SEND) && empty;
            ab_evt     <= (st == ST_SEND) && tx_err;
            fill_abort <= flush;
            if (cut)        evt_frame <= frame_q;
            if (cut || fin) frame_q   <= frame_q + 1'b1;
        end
    end

    // R6: an error in SEND silences the media on the next cycle
    p_err_silences_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && tx_err) |=> (!tx_en && ab_evt));
    // R5: a dry queue in SEND gives an underflow pulse and no byte
    p_underflow_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && empty) |=> (uf_evt && !tx_en));
    // R5: the underflow pulse lasts one cycle
    p_uf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> !uf_evt);
    // R7: a DMA stop only follows a cut whose end flag was missing
    p_fill_abort_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_abort |-> $past(!eof_held));
    // R8: discarded bytes never reach the media
    p_drain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN) |=> !tx_en);
    // R11: an error outside a frame raises no abort
    p_idle_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SEND) |=> !ab_evt);

endmodule

// File: rtl/tx_gate_fifo.sv
module tx_gate_fifo
    import txg_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned THR_INIT = 4,
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_we,
    input  logic [CW-1:0]     thr_val,
    input  logic              fill_valid,
    input  logic [TXG_DW-1:0] fill_data,
    input  logic              fill_last,
    output logic              fill_ready,
    output logic              fill_abort,
    input  logic              tx_err,
    output logic              tx_en,
    output logic [TXG_DW-1:0] tx_data,
    output logic              tx_eop,
    output logic              underflow_event,
    output logic              abort_event,
    output logic [IDX_W-1:0]  event_frame
);

    txg_slot_t     wr_slot, head;
    logic [CW-1:0] level;
    logic          eof_held, full, empty, start_ok, rd_en, flush, wr_en;

    assign fill_ready = !full && !flush;
    assign wr_en      = fill_valid && fill_ready;
    assign wr_slot    = '{eof: fill_last, byte_v: fill_data};

    txg_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .rd_en    (rd_en),
        .flush    (flush),
        .head     (head),
        .level    (level),
        .eof_held (eof_held),
        .full     (full),
        .empty    (empty)
    );

    txg_start_cmp #(.DEPTH(DEPTH), .THR_INIT(THR_INIT)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_we   (thr_we),
        .thr_val  (thr_val),
        .level    (level),
        .eof_held (eof_held),
        .full     (full),
        .start_ok (start_ok)
    );

    txg_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .empty      (empty),
        .eof_held   (eof_held),
        .head       (head),
        .tx_err     (tx_err),
        .rd_en      (rd_en),
        .flush      (flush),
        .tx_en      (tx_en),
        .tx_data    (tx_data),
        .tx_eop     (tx_eop),
        .uf_evt     (underflow_event),
        .ab_evt     (abort_event),
        .fill_abort (fill_abort),
        .evt_frame  (event_frame)
    );

    // R12: coinciding cut causes give a single DMA stop pulse
    p_single_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_event && abort_event) |=> !fill_abort);

endmodule

// File: tb/sim_tx_gate_fifo.sv
`timescale 1ns/1ps
module sim_tx_gate_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr_we = 1'b0;
    logic [4:0] thr_val = '0;
    logic       fill_valid = 1'b0;
    logic [7:0] fill_data = '0;
    logic       fill_last = 1'b0;
    logic       fill_ready, fill_abort;
    logic       tx_err = 1'b0;
    logic       tx_en, tx_eop, underflow_event, abort_event;
    logic [7:0] tx_data;
    logic [7:0] event_frame;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] cap_d [0:511];
    bit         cap_e [0:511];
    int cap_n = 0, uf_cnt = 0, ab_cnt = 0, fa_cnt = 0, both_cnt = 0;
    int uf_frame = -1, ab_frame = -1;

    always #2 clk = ~clk;

    tx_gate_fifo u0 (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_val(thr_val),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_last(fill_last),
        .fill_ready(fill_ready), .fill_abort(fill_abort), .tx_err(tx_err),
        .tx_en(tx_en), .tx_data(tx_data), .tx_eop(tx_eop),
        .underflow_event(underflow_event), .abort_event(abort_event),
        .event_frame(event_frame)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                cap_d[cap_n] = tx_data;
                cap_e[cap_n] = tx_eop;
                cap_n = cap_n + 1;
            end
            if (underflow_event) begin uf_cnt = uf_cnt + 1; uf_frame = event_frame; end
            if (abort_event)     begin ab_cnt = ab_cnt + 1; ab_frame = event_frame; end
            if (underflow_event && abort_event) both_cnt = both_cnt + 1;
            if (fill_abort) fa_cnt = fa_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_thr(input int v);
        thr_we = 1'b1; thr_val = 5'(v);
        tick();
        thr_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input bit last, inout int stalls);
        bit ok;
        fill_valid = 1'b1; fill_data = d; fill_last = last;
        forever begin
            ok = fill_ready;
            tick();
            if (ok) break;
            stalls++;
        end
        fill_valid = 1'b0; fill_last = 1'b0;
    endtask

    // compare captured bytes [from, from+n) against base+i, eop only on the last
    task automatic cmp_frame(input string tag, input int from, input int n,
                             input logic [7:0] base, input bit has_eop);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (cap_d[from+i] != base + 8'(i)) bad++;
            if (cap_e[from+i] != (has_eop && i == n-1)) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 fill_ready", fill_ready, 1);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 events", underflow_event + abort_event + fill_abort + tx_eop, 0);
        chk("R1 event_frame", event_frame, 0);
    endtask

    task automatic t_threshold();
        int st = 0, c0 = cap_n, u0c = uf_cnt;
        set_thr(5);
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i), 1'b0, st);
        tick(4);
        chk("R2 held at level==thr", cap_n - c0, 0);
        for (int i = 5; i < 10; i++) push(8'h10 + 8'(i), i == 9, st);
        tick(12);
        chk("R4 byte count", cap_n - c0, 10);
        cmp_frame("R4 order and eop", c0, 10, 8'h10, 1'b1);
        chk("R4 no underflow", uf_cnt - u0c, 0);
    endtask

    task automatic t_underflow();
        int st = 0, c0 = cap_n, u0c = uf_cnt, f0 = fa_cnt, a0 = ab_cnt;
        set_thr(0);
        push(8'hA5, 1'b0, st);
        tick(6);
        chk("R2 zero threshold sends one byte", cap_n - c0, 1);
        chk("R5 underflow pulse", uf_cnt - u0c, 1);
        chk("R7 fill_abort on underflow", fa_cnt - f0, 1);
        chk("R6 no abort_event", ab_cnt - a0, 0);
        chk("R9 underflow frame index", uf_frame, 1);
    endtask

    task automatic t_short();
        int st = 0, c0 = cap_n;
        set_thr(8);
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i), i == 2, st);
        tick(8);
        chk("R3 short frame sent", cap_n - c0, 3);
        cmp_frame("R3 short frame content", c0, 3, 8'h20, 1'b1);
    endtask

    task automatic t_full();
        int st = 0, c0 = cap_n, u0c = uf_cnt;
        set_thr(16);
        for (int i = 0; i < 20; i++) push(8'h40 + 8'(i), i == 19, st);
        tick(20);
        chk("R10 stall when full", (st > 0) ? 1 : 0, 1);
        chk("R3 full start count", cap_n - c0, 20);
        cmp_frame("R10 no overwrite", c0, 20, 8'h40, 1'b1);
        chk("R3 no underflow", uf_cnt - u0c, 0);
    endtask

    task automatic t_abort_unfilled();
        int st = 0, c0 = cap_n, f0 = fa_cnt, a0 = ab_cnt;
        set_thr(3);
        for (int i = 0; i < 4; i++) push(8'h50 + 8'(i), 1'b0, st);
        tick();
        tx_err = 1'b1;
        #1;
        chk("R7 fill_ready low in cut cycle", fill_ready, 0);
        tick();
        tx_err = 1'b0;
        tick(4);
        chk("R6 abort_event", ab_cnt - a0, 1);
        chk("R6 only first byte sent", cap_n - c0, 1);
        chk("R7 fill_abort pulse", fa_cnt - f0, 1);
        chk("R9 abort frame index", ab_frame, 4);
        c0 = cap_n;
        for (int i = 0; i < 3; i++) push(8'h58 + 8'(i), i == 2, st);
        tick(8);
        chk("R7 queue emptied, next frame length", cap_n - c0, 3);
        cmp_frame("R7 next frame content", c0, 3, 8'h58, 1'b1);
    endtask

    task automatic t_abort_stored();
        int st = 0, c0 = cap_n, f0 = fa_cnt, a0 = ab_cnt;
        set_thr(3);
        fork
            begin
                for (int i = 0; i < 6; i++) push(8'h60 + 8'(i), i == 5, st);
                for (int i = 0; i < 3; i++) push(8'h70 + 8'(i), i == 2, st);
            end
            begin
                tick(6);
                tx_err = 1'b1;
                tick();
                tx_err = 1'b0;
            end
        join
        tick(12);
        chk("R8 abort_event", ab_cnt - a0, 1);
        chk("R8 no fill_abort", fa_cnt - f0, 0);
        chk("R8 sent byte count", cap_n - c0, 5);
        cmp_frame("R8 cut frame head", c0, 2, 8'h60, 1'b0);
        cmp_frame("R8 next frame intact", c0 + 2, 3, 8'h70, 1'b1);
        chk("R9 abort frame index", ab_frame, 6);
    endtask

    task automatic t_both();
        int st = 0, b0 = both_cnt, f0 = fa_cnt;
        set_thr(0);
        push(8'h80, 1'b0, st);
        tick();
        tx_err = 1'b1;
        tick();
        tx_err = 1'b0;
        tick(4);
        chk("R12 both pulses together", both_cnt - b0, 1);
        chk("R12 single fill_abort", fa_cnt - f0, 1);
        chk("R12 frame index underflow", uf_frame, 8);
        chk("R12 frame index abort", ab_frame, 8);
    endtask

    task automatic t_idle_err();
        int st = 0, a0 = ab_cnt, c0 = cap_n, bad = 0;
        tx_err = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (!fill_ready) bad++;
            tick();
        end
        tx_err = 1'b0;
        tick(2);
        chk("R11 fill_ready kept", bad, 0);
        chk("R11 no abort_event", ab_cnt - a0, 0);
        for (int i = 0; i < 2; i++) push(8'h90 + 8'(i), i == 1, st);
        tick(6);
        chk("R11 later frame intact", cap_n - c0, 2);
        cmp_frame("R11 later frame content", c0, 2, 8'h90, 1'b1);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_underflow();
        t_short();
        t_full();
        t_abort_unfilled();
        t_abort_stored();
        t_both();
        t_idle_err();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule